// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Write-Read Behaviour

This block is a single-clock memory with one address port. Reads and writes share that port. Each write can be limited to chosen byte lanes. The data output is registered, so a word read at one clock edge appears on the output after that edge.

Two elaboration choices set what the output shows when a write and an enabled read fall on the same edge:
- The output can show the merged word being written.
- The output can show the word that the write replaces.
- The output can be left unspecified.

A second choice decides whether the read-enable pin is honoured at all. When it is honoured and read enable is low, the output keeps the last value it loaded, even while writes go on.

Three more controls complete the port:
- An address stall makes the memory keep using the last latched address.
- A clock enable freezes every piece of state.
- An asynchronous clear empties the output register without touching the stored words.

Top module: `sp_sync_ram`

## Requirements
- R1: A read at the clock edge where `rd_en` is high, `wr_en` is low and `clk_en` is high puts the stored word at the effective address on `rdata` after that same edge (one cycle of latency).
- R2: A write stores only the lanes whose `lane_en` bit is set. Lane i is bits [i*LANE_W+LANE_W-1 : i*LANE_W] of `wdata`. All other lanes keep their previous contents.
- R3: With `RDW_MODE` = RDW_NEW (value 0), a write with an enabled read loads `rdata` with the merged word: the new enabled lanes plus the old disabled lanes.
- R4: With `RDW_MODE` = RDW_OLD (value 1), a write with an enabled read loads `rdata` with the word stored at that address before the write.
- R5: With `RDW_MODE` = RDW_DONTCARE (value 2), the output during a write with an enabled read is unspecified. The write itself still takes effect.
- R6: With `USE_RDEN` = 1, `rdata` holds its value at every edge where `rd_en` is low, including edges that carry a write.
- R7: With `USE_RDEN` = 0, `rd_en` is ignored and every enabled edge is a read.
- R8: While `addr_hold` is high, reads and writes use the last address latched while `addr_hold` was low, and `addr` is ignored.
- R9: While `clk_en` is low, no write happens, `rdata` does not change, and the latched address does not change.
- R10: `aclr` high forces `rdata` to zero at once, without waiting for a clock edge. The stored words are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all synchronous state |
| aclr | input | 1 | Asynchronous clear of the output register, active high |
| clk_en | input | 1 | Clock enable; low freezes all state |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request (used only when USE_RDEN = 1) |
| addr_hold | input | 1 | Address stall: keep the previously latched address |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| lane_en | input | DATA_W/LANE_W | Per-lane write enables |
| rdata | output | DATA_W | Registered read data |

## Verification
The bench drives four instances from the same inputs:
- new-data mode with read enable honoured;
- old-data mode with read enable honoured;
- don't-care mode with read enable honoured;
- new-data mode with read enable ignored.

The same stimulus therefore shows the modes apart. A write with read enable high makes the new-data output differ from the old-data output. A write with read enable low leaves the honouring instances still, while the instance that ignores read enable moves.

Full-lane writes are contrasted with sparse lane masks, so a merge error shows as a wrong lane. Stalled reads and writes are aimed at an address whose contents differ from those at the stalled address. A blocked clock enable and a clear raised between edges show that writes and stored data survive only where they should.

// File: rtl/spram_pkg.sv
package spram_pkg;

  // Output behaviour for a write that coincides with an enabled read.
  // The encoding is visible through the RDW_MODE parameter.
  typedef enum logic [1:0] {
    RDW_NEW      = 2'd0,
    RDW_OLD      = 2'd1,
    RDW_DONTCARE = 2'd2
  } rdw_mode_e;

endpackage

// File: rtl/spram_addr_stage.sv
module spram_addr_stage #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              addr_hold,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] addr_eff
);

  // Latched address; updated only when enabled and not stalled.
  always_ff @(posedge clk) begin
    if (clk_en && !addr_hold) begin
      addr_q <= addr_in;
    end
  end

  // A stall reuses the latched address; otherwise the live input is used.
  assign addr_eff = addr_hold ? addr_q : addr_in;

endmodule

// File: rtl/spram_array.sv
module spram_array #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W/LANE_W-1:0] lane_en,
  output logic [DATA_W-1:0] old_word,
  output logic [DATA_W-1:0] new_word
);

  localparam int LANES = DATA_W / LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Replace each enabled lane of the stored word with the matching lane of the incoming data.
  function automatic logic [DATA_W-1:0] lane_merge(
    input logic [DATA_W-1:0] stored,
    input logic [DATA_W-1:0] incoming,
    input logic [LANES-1:0]  enables
  );
    logic [DATA_W-1:0] res;
    res = stored;
    for (int l = 0; l < LANES; l++) begin
      if (enables[l]) begin
        res[l*LANE_W +: LANE_W] = incoming[l*LANE_W +: LANE_W];
      end
    end
    return res;
  endfunction

  assign old_word = mem[addr];
  assign new_word = lane_merge(old_word, wdata, lane_en);

  // A single write port stores the merged word.
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[addr] <= new_word;
    end
  end

endmodule

// File: rtl/spram_out_reg.sv
module spram_out_reg
  import spram_pkg::*;
#(
  parameter int        DATA_W   = 36,
  parameter rdw_mode_e RDW_MODE = RDW_NEW
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              rd_fire,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_word,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] collide_word;

  // The mode is fixed at elaboration, so no runtime mux is built.
  generate
    if (RDW_MODE == RDW_NEW) begin : g_new
      assign collide_word = new_word;
    end else if (RDW_MODE == RDW_OLD) begin : g_old
      assign collide_word = old_word;
    end else begin : g_dc
      assign collide_word = {DATA_W{1'bx}};
    end
  endgenerate

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      rdata <= '0;
    end else if (rd_fire) begin
      rdata <= wr_fire ? collide_word : old_word;
    end
  end

endmodule

// File: rtl/sp_sync_ram.sv
module sp_sync_ram
  import spram_pkg::*;
#(
  parameter int        DATA_W   = 36,
  parameter int        ADDR_W   = 8,
  parameter int        LANE_W   = 9,
  parameter rdw_mode_e RDW_MODE = RDW_NEW,
  parameter bit        USE_RDEN = 1'b1
) (
  input  logic                     clk,
  input  logic                     aclr,
  input  logic                     clk_en,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic                     addr_hold,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W/LANE_W-1:0] lane_en,
  output logic [DATA_W-1:0]        rdata
);

  localparam int LANES = DATA_W / LANE_W;

  // Internal events, named so the checker can observe them.
  logic              wr_fire;
  logic              rd_fire;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] new_word;
  logic [LANES-1:0]  lanes;

  assign lanes   = lane_en;
  assign wr_fire = clk_en & wr_en;

  generate
    if (USE_RDEN) begin : g_rden
      assign rd_fire = clk_en & rd_en;
    end else begin : g_no_rden
      assign rd_fire = clk_en;
    end
  endgenerate

  spram_addr_stage #(.ADDR_W(ADDR_W)) addr_stage_i (
    .clk       (clk),
    .clk_en    (clk_en),
    .addr_hold (addr_hold),
    .addr_in   (addr),
    .addr_q    (addr_q),
    .addr_eff  (addr_eff)
  );

  spram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) array_i (
    .clk      (clk),
    .wr_fire  (wr_fire),
    .addr     (addr_eff),
    .wdata    (wdata),
    .lane_en  (lanes),
    .old_word (old_word),
    .new_word (new_word)
  );

  spram_out_reg #(.DATA_W(DATA_W), .RDW_MODE(RDW_MODE)) out_reg_i (
    .clk      (clk),
    .aclr     (aclr),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .old_word (old_word),
    .new_word (new_word),
    .rdata    (rdata)
  );

endmodule

// File: rtl/spram_checker.sv
module spram_checker
  import spram_pkg::*;
#(
  parameter int        DATA_W   = 36,
  parameter int        ADDR_W   = 8,
  parameter rdw_mode_e RDW_MODE = RDW_NEW
) (
  input logic              clk,
  input logic              aclr,
  input logic              clk_en,
  input logic              addr_hold,
  input logic              rd_fire,
  input logic              wr_fire,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DATA_W-1:0] old_word,
  input logic [DATA_W-1:0] new_word,
  input logic [DATA_W-1:0] rdata
);

  a_r1_plain_read: assert property (@(posedge clk) disable iff (aclr)
    (rd_fire && !wr_fire) |=> rdata == $past(old_word));

  a_r3_new_on_collide: assert property (@(posedge clk) disable iff (aclr)
    (RDW_MODE == RDW_NEW && rd_fire && wr_fire) |=> rdata == $past(new_word));

  a_r4_old_on_collide: assert property (@(posedge clk) disable iff (aclr)
    (RDW_MODE == RDW_OLD && rd_fire && wr_fire) |=> rdata == $past(old_word));

  a_r6_hold_without_read: assert property (@(posedge clk) disable iff (aclr)
    !rd_fire |=> $stable(rdata));

  a_r8_stall_keeps_addr: assert property (@(posedge clk) disable iff (aclr)
    addr_hold |=> $stable(addr_q));

  a_r9_frozen_when_disabled: assert property (@(posedge clk) disable iff (aclr)
    !clk_en |=> ($stable(rdata) && $stable(addr_q)));

  a_r10_clear_zeroes_output: assert property (@(posedge clk)
    aclr |-> rdata == '0);

endmodule

bind sp_sync_ram spram_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .RDW_MODE (RDW_MODE)
) checker_i (
  .clk       (clk),
  .aclr      (aclr),
  .clk_en    (clk_en),
  .addr_hold (addr_hold),
  .rd_fire   (rd_fire),
  .wr_fire   (wr_fire),
  .addr_q    (addr_q),
  .old_word  (old_word),
  .new_word  (new_word),
  .rdata     (rdata)
);

// File: tb/sp_sync_ram_tb_top.sv
module sp_sync_ram_tb_top;
  import spram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 36;
  localparam int AW = 8;
  localparam int LW = 9;
  localparam int NL = DW / LW;

  logic          clk = 1'b0;
  logic          aclr;
  logic          clk_en;
  logic          wr_en;
  logic          rd_en;
  logic          addr_hold;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NL-1:0] lane_en;
  logic [DW-1:0] q_new, q_old, q_dc, q_free;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [1<<AW];
  logic [AW-1:0] ref_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_sync_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .RDW_MODE(RDW_NEW), .USE_RDEN(1'b1)) dut_i (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .wr_en(wr_en), .rd_en(rd_en), .addr_hold(addr_hold),
    .addr(addr), .wdata(wdata), .lane_en(lane_en), .rdata(q_new));

  sp_sync_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .RDW_MODE(RDW_OLD), .USE_RDEN(1'b1)) dut_old_i (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .wr_en(wr_en), .rd_en(rd_en), .addr_hold(addr_hold),
    .addr(addr), .wdata(wdata), .lane_en(lane_en), .rdata(q_old));

  sp_sync_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .RDW_MODE(RDW_DONTCARE), .USE_RDEN(1'b1)) dut_dc_i (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .wr_en(wr_en), .rd_en(rd_en), .addr_hold(addr_hold),
    .addr(addr), .wdata(wdata), .lane_en(lane_en), .rdata(q_dc));

  sp_sync_ram #(.DATA_W(DW), .ADDR_W(AW), .LANE_W(LW), .RDW_MODE(RDW_NEW), .USE_RDEN(1'b0)) dut_free_i (
    .clk(clk), .aclr(aclr), .clk_en(clk_en), .wr_en(wr_en), .rd_en(rd_en), .addr_hold(addr_hold),
    .addr(addr), .wdata(wdata), .lane_en(lane_en), .rdata(q_free));

  // Bench model of a lane-masked write: widen the lane mask to a bit mask, then blend.
  function automatic logic [DW-1:0] blend(input logic [DW-1:0] prev, input logic [DW-1:0] d,
                                          input logic [NL-1:0] le);
    logic [DW-1:0] m;
    for (int b = 0; b < DW; b++) m[b] = le[b / LW];
    return (d & m) | (prev & ~m);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Apply one cycle of stimulus after a falling edge; return at the next falling edge.
  task automatic step(input bit we, input bit re, input bit ce, input bit hold,
                      input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] le);
    logic [AW-1:0] eff;
    wr_en = we; rd_en = re; clk_en = ce; addr_hold = hold; addr = a; wdata = d; lane_en = le;
    eff = hold ? ref_lat : a;
    if (ce && we) ref_mem[eff] = blend(ref_mem[eff], d, le);
    if (ce && !hold) ref_lat = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset new", q_new, '0);
    check("R10 reset old", q_old, '0);
    check("R10 reset free", q_free, '0);
  endtask

  task automatic t_basic();
    step(1, 0, 1, 0, 8'd5, 36'h1_2345_6789, 4'hF);
    step(1, 0, 1, 0, 8'd7, 36'hA_BCDE_F012, 4'hF);
    step(1, 0, 1, 0, 8'd9, 36'h5_5555_AAAA, 4'hF);
    check("R6 no read since reset", q_new, '0);
    step(0, 1, 1, 0, 8'd5, '0, '0);
    check("R1 read addr5", q_new, 36'h1_2345_6789);
    check("R1 read addr5 old-mode", q_old, 36'h1_2345_6789);
  endtask

  task automatic t_lanes();
    step(1, 0, 1, 0, 8'd5, 36'hF_FFFF_FFFF, 4'b0101);
    step(0, 1, 1, 0, 8'd5, '0, '0);
    check("R2 lane merge", q_new, blend(36'h1_2345_6789, 36'hF_FFFF_FFFF, 4'b0101));
  endtask

  task automatic t_rdw();
    logic [DW-1:0] prior, merged;
    prior  = ref_mem[5];
    merged = blend(prior, 36'h0_0C3C_3C3C, 4'b0011);
    step(1, 1, 1, 0, 8'd5, 36'h0_0C3C_3C3C, 4'b0011);
    check("R3 new-data collide", q_new, merged);
    check("R4 old-data collide", q_old, prior);
    check("R3 new-data collide, read enable ignored", q_free, merged);
    step(0, 1, 1, 0, 8'd5, '0, '0);
    check("R5 dont-care write stored", q_dc, merged);
  endtask

  task automatic t_rden_low();
    step(0, 1, 1, 0, 8'd7, '0, '0);
    check("R1 read addr7", q_new, 36'hA_BCDE_F012);
    step(1, 0, 1, 0, 8'd5, 36'h7_0F0F_1234, 4'hF);
    check("R6 hold on write, read off", q_new, 36'hA_BCDE_F012);
    check("R7 read enable ignored", q_free, 36'h7_0F0F_1234);
    step(0, 1, 1, 0, 8'd5, '0, '0);
    check("R6 write still stored", q_new, 36'h7_0F0F_1234);
  endtask

  task automatic t_stall();
    step(0, 1, 1, 0, 8'd9, '0, '0);
    check("R1 read addr9", q_new, 36'h5_5555_AAAA);
    step(0, 1, 1, 1, 8'd7, '0, '0);
    check("R8 stalled read uses addr9", q_new, 36'h5_5555_AAAA);
    step(1, 0, 1, 1, 8'd7, 36'h3_1415_9265, 4'hF);
    step(0, 1, 1, 0, 8'd7, '0, '0);
    check("R8 addr7 untouched by stalled write", q_new, 36'hA_BCDE_F012);
    step(0, 1, 1, 0, 8'd9, '0, '0);
    check("R8 stalled write hit addr9", q_new, 36'h3_1415_9265);
  endtask

  task automatic t_clken();
    step(1, 1, 0, 0, 8'd7, 36'hD_EADB_EEF0, 4'hF);
    check("R9 output frozen", q_new, 36'h3_1415_9265);
    check("R9 output frozen, read enable ignored", q_free, 36'h3_1415_9265);
    step(0, 1, 1, 0, 8'd7, '0, '0);
    check("R9 write blocked", q_new, 36'hA_BCDE_F012);
  endtask

  task automatic t_aclr();
    #2 aclr = 1'b1;
    #1;
    check("R10 async clear new", q_new, '0);
    check("R10 async clear old", q_old, '0);
    @(negedge clk);
    aclr = 1'b0;
    step(0, 1, 1, 0, 8'd7, '0, '0);
    check("R10 memory intact", q_new, 36'hA_BCDE_F012);
  endtask

  initial begin
    aclr = 1'b1; clk_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr_hold = 1'b0;
    addr = '0; wdata = '0; lane_en = '0; ref_lat = '0;
    repeat (3) @(negedge clk);
    t_reset();
    aclr = 1'b0;
    @(negedge clk);
    t_basic();
    t_lanes();
    t_rdw();
    t_rden_low();
    t_stall();
    t_clken();
    t_aclr();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule